// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block generates data-memory addresses from a small set of pointer contexts. Each of its four contexts holds a pointer, a buffer start, a buffer span and a signed step. A request names one context and an addressing mode, and can carry an immediate offset. The block returns the memory address for that access and the pointer value that results from it. When the mode moves the pointer, the block keeps the pointer inside its buffer by wrapping it around. The buffer may begin at any address and may have any span. A bit-reversed update is also available for transform-style traversal.

Each access is marked as one, two or four words wide. The block checks that the address it produces is aligned to that width. A request that fails this check is flagged and leaves the pointer unchanged. Software loads the contexts through a plain field-write port. The response is registered, so it appears one cycle after the request. The pointer register changes on the same clock edge, which lets a request in the very next cycle use the new value.

Top module: `cbuf_agu`

## Requirements
- R1: Config writes select a context and a field: code 0 is the pointer, 1 the buffer start, 2 the buffer span and 3 the step, which is two's complement. If a config write to the pointer lands in the same cycle as a pointer update of the same context, the written value wins.
- R2: After reset every context field is zero and `rsp_valid` and `rsp_err` are low. `rsp_valid` is high in the cycle after each cycle with `req_valid` high, and low in every other cycle.
- R3: Post-modify (mode code 2) returns the current pointer as the address. It returns the updated pointer on `rsp_ptr` and stores that value.
- R4: Pre-modify (mode code 1) computes the updated pointer, returns it as both the address and `rsp_ptr`, and stores it.
- R5: Immediate mode (mode code 0) returns pointer + `req_imm` as the address. The stored pointer does not change, and `rsp_ptr` shows that stored value.
- R6: With a non-zero span, the update first forms s = pointer + step. If s ≥ start + span, the result is s − span. If s < start, the result is s + span. Otherwise the result is s.
- R7: With a span of zero, the update is pointer + step with no wraparound.
- R8: With `req_brev` high, the update works on the offset (pointer − start). It adds the low REV_BITS of the step to the low REV_BITS of that offset, with the carry moving from the most significant bit toward the least significant bit. The upper offset bits stay as they are, and the result is start + new offset. The span is not used.
- R9: Size code 0 is one word, 1 is two words and 2 is four words. A two-word access needs address bit 0 clear, and a four-word access needs address bits 1:0 clear. Size code 3 and mode code 3 are always errors. On an error `rsp_err` is high, the address is still reported, and the pointer is neither stored nor advanced, so `rsp_ptr` shows the old pointer.
- R10: Back-to-back requests to the same context see the pointer that the previous request stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_ctx | input | CW | Context written |
| cfg_fld | input | 2 | Field code (0 pointer, 1 start, 2 span, 3 step) |
| cfg_wdata | input | AW | Value written |
| req_valid | input | 1 | Access request |
| req_ctx | input | CW | Context used |
| req_mode | input | 2 | 0 immediate, 1 pre-modify, 2 post-modify, 3 reserved |
| req_size | input | 2 | 0 one word, 1 two words, 2 four words, 3 reserved |
| req_brev | input | 1 | Use the bit-reversed update instead of the modulo update |
| req_imm | input | AW | Immediate offset |
| rsp_valid | output | 1 | Response valid |
| rsp_addr | output | AW | Generated address |
| rsp_ptr | output | AW | Pointer after the access |
| rsp_err | output | 1 | Alignment or encoding error |

## Verification
The hardest situations to reach are a wrap in the downward direction, and a misaligned request that arrives just after a wrap. In that second case the error has to stop a pointer that would otherwise have moved back into the buffer. Directed cases build exact wraps on both edges, a zero-span linear pointer, and a bit-reversed walk with known addresses. A random phase then programs buffers at unaligned starts with odd spans and steps up to the full span, and sends mixed modes and sizes back to back. Because the starts and steps are unaligned, alignment failures fall naturally between successful updates.

// File: rtl/cbuf_agu_pkg.sv
package cbuf_agu_pkg;
   typedef enum logic [1:0] {
      AM_IMM  = 2'd0,
      AM_PRE  = 2'd1,
      AM_POST = 2'd2,
      AM_RSVD = 2'd3
   } am_mode_e;

   typedef enum logic [1:0] {
      SZ_ONE  = 2'd0,
      SZ_TWO  = 2'd1,
      SZ_FOUR = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   typedef enum logic [1:0] {
      FLD_PTR  = 2'd0,
      FLD_BASE = 2'd1,
      FLD_LEN  = 2'd2,
      FLD_STEP = 2'd3
   } fld_e;
endpackage

// File: rtl/cbuf_ctx_regs.sv
module cbuf_ctx_regs
   import cbuf_agu_pkg::*;
#(
   parameter int AW      = 32,
   parameter int NUM_CTX = 4,
   localparam int CW     = $clog2(NUM_CTX)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [CW-1:0] wr_ctx,
   input  logic [1:0]    wr_fld,
   input  logic [AW-1:0] wr_data,
   input  logic          upd_en,
   input  logic [CW-1:0] upd_ctx,
   input  logic [AW-1:0] upd_ptr,
   input  logic [CW-1:0] rd_ctx,
   output logic [AW-1:0] rd_ptr,
   output logic [AW-1:0] rd_base,
   output logic [AW-1:0] rd_len,
   output logic [AW-1:0] rd_step
);
   logic [AW-1:0] ptr_q  [NUM_CTX];
   logic [AW-1:0] base_q [NUM_CTX];
   logic [AW-1:0] len_q  [NUM_CTX];
   logic [AW-1:0] step_q [NUM_CTX];

   fld_e fld;
   assign fld = fld_e'(wr_fld);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_CTX; i++) begin
            ptr_q[i]  <= '0;
            base_q[i] <= '0;
            len_q[i]  <= '0;
            step_q[i] <= '0;
         end
      end else begin
         for (int i = 0; i < NUM_CTX; i++) begin
            if (wr_en && wr_ctx == CW'(i) && fld == FLD_PTR)
               ptr_q[i] <= wr_data;
            else if (upd_en && upd_ctx == CW'(i))
               ptr_q[i] <= upd_ptr;
            if (wr_en && wr_ctx == CW'(i) && fld == FLD_BASE) base_q[i] <= wr_data;
            if (wr_en && wr_ctx == CW'(i) && fld == FLD_LEN)  len_q[i]  <= wr_data;
            if (wr_en && wr_ctx == CW'(i) && fld == FLD_STEP) step_q[i] <= wr_data;
         end
      end
   end

   assign rd_ptr  = ptr_q[rd_ctx];
   assign rd_base = base_q[rd_ctx];
   assign rd_len  = len_q[rd_ctx];
   assign rd_step = step_q[rd_ctx];
endmodule

// File: rtl/cbuf_mod_step.sv
module cbuf_mod_step #(
   parameter int AW = 32,
   localparam int EW = AW + 2
) (
   input  logic [AW-1:0] ptr,
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] len,
   input  logic [AW-1:0] step,
   output logic [AW-1:0] nxt
);
   logic signed [EW-1:0] sum_e, base_e, end_e;
   logic                 over, under;
   logic [AW-1:0]        sum_w;

   always_comb begin
      sum_e  = $signed({2'b00, ptr}) + $signed({{2{step[AW-1]}}, step});
      base_e = $signed({2'b00, base});
      end_e  = base_e + $signed({2'b00, len});
      over   = (len != '0) && (sum_e >= end_e);
      under  = (len != '0) && (sum_e < base_e);
      sum_w  = ptr + step;
      if (over)       nxt = sum_w - len;
      else if (under) nxt = sum_w + len;
      else            nxt = sum_w;
   end
endmodule

// File: rtl/cbuf_rev_step.sv
module cbuf_rev_step #(
   parameter int AW = 32,
   parameter int RB = 8
) (
   input  logic [AW-1:0] ptr,
   input  logic [AW-1:0] base,
   input  logic [RB-1:0] step_lo,
   output logic [AW-1:0] nxt
);
   function automatic logic [RB-1:0] flip(input logic [RB-1:0] v);
      logic [RB-1:0] r;
      for (int i = 0; i < RB; i++) r[i] = v[RB-1-i];
      return r;
   endfunction

   logic [AW-1:0] off, off_n;
   logic [RB-1:0] rsum;

   always_comb begin
      off   = ptr - base;
      rsum  = flip(off[RB-1:0]) + flip(step_lo);
      off_n = {off[AW-1:RB], flip(rsum)};
      nxt   = base + off_n;
   end
endmodule

// File: rtl/cbuf_agu.sv
module cbuf_agu
   import cbuf_agu_pkg::*;
#(
   parameter int AW       = 32,
   parameter int NUM_CTX  = 4,
   parameter int REV_BITS = 8,
   localparam int CW      = $clog2(NUM_CTX)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [CW-1:0] cfg_ctx,
   input  logic [1:0]    cfg_fld,
   input  logic [AW-1:0] cfg_wdata,
   input  logic          req_valid,
   input  logic [CW-1:0] req_ctx,
   input  logic [1:0]    req_mode,
   input  logic [1:0]    req_size,
   input  logic          req_brev,
   input  logic [AW-1:0] req_imm,
   output logic          rsp_valid,
   output logic [AW-1:0] rsp_addr,
   output logic [AW-1:0] rsp_ptr,
   output logic          rsp_err
);
   if (AW < 4) begin : g_bad_aw
      $error("cbuf_agu: AW must be at least 4");
   end
   if (NUM_CTX < 2 || (1 << CW) != NUM_CTX) begin : g_bad_ctx
      $error("cbuf_agu: NUM_CTX must be a power of two >= 2");
   end
   if (REV_BITS < 0 || REV_BITS >= AW) begin : g_bad_rb
      $error("cbuf_agu: REV_BITS must be in [0, AW)");
   end

   am_mode_e  mode;
   acc_size_e size;
   assign mode = am_mode_e'(req_mode);
   assign size = acc_size_e'(req_size);

   logic [AW-1:0] cur_ptr, cur_base, cur_len, cur_step;
   logic [AW-1:0] mod_nxt, upd_nxt, eff_addr, out_ptr;
   logic          err, do_upd;

   cbuf_ctx_regs #(.AW(AW), .NUM_CTX(NUM_CTX)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_ctx  (cfg_ctx),
      .wr_fld  (cfg_fld),
      .wr_data (cfg_wdata),
      .upd_en  (do_upd),
      .upd_ctx (req_ctx),
      .upd_ptr (upd_nxt),
      .rd_ctx  (req_ctx),
      .rd_ptr  (cur_ptr),
      .rd_base (cur_base),
      .rd_len  (cur_len),
      .rd_step (cur_step)
   );

   cbuf_mod_step #(.AW(AW)) u_mod (
      .ptr  (cur_ptr),
      .base (cur_base),
      .len  (cur_len),
      .step (cur_step),
      .nxt  (mod_nxt)
   );

   if (REV_BITS > 0) begin : g_rev
      logic [AW-1:0] rev_nxt;
      cbuf_rev_step #(.AW(AW), .RB(REV_BITS)) u_rev (
         .ptr     (cur_ptr),
         .base    (cur_base),
         .step_lo (cur_step[REV_BITS-1:0]),
         .nxt     (rev_nxt)
      );
      assign upd_nxt = req_brev ? rev_nxt : mod_nxt;
   end else begin : g_norev
      assign upd_nxt = mod_nxt;
   end

   always_comb begin
      unique case (mode)
         AM_IMM:  eff_addr = cur_ptr + req_imm;
         AM_PRE:  eff_addr = upd_nxt;
         default: eff_addr = cur_ptr;
      endcase
      unique case (size)
         SZ_ONE:  err = 1'b0;
         SZ_TWO:  err = eff_addr[0];
         SZ_FOUR: err = |eff_addr[1:0];
         default: err = 1'b1;
      endcase
      if (mode == AM_RSVD) err = 1'b1;
      do_upd  = req_valid && !err && (mode == AM_PRE || mode == AM_POST);
      out_ptr = do_upd ? upd_nxt : cur_ptr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_addr  <= '0;
         rsp_ptr   <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= req_valid && err;
         if (req_valid) begin
            rsp_addr <= eff_addr;
            rsp_ptr  <= out_ptr;
         end
      end
   end
endmodule

// File: rtl/cbuf_agu_chk.sv
module cbuf_agu_chk
   import cbuf_agu_pkg::*;
#(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic [1:0]    req_mode,
   input logic [1:0]    req_size,
   input logic          rsp_valid,
   input logic [AW-1:0] rsp_addr,
   input logic [AW-1:0] rsp_ptr,
   input logic          rsp_err
);
   assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid && !rsp_err);

   assert_pre_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_mode == AM_PRE |=> rsp_err || rsp_addr == rsp_ptr);

   assert_align_two_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_size == SZ_TWO |=> rsp_err || !rsp_addr[0]);

   assert_align_four_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_size == SZ_FOUR |=> rsp_err || rsp_addr[1:0] == 2'b00);

   assert_err_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_mode == AM_POST |=> !rsp_err || rsp_ptr == rsp_addr);

   assert_bad_size_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_size == SZ_RSVD |=> rsp_err);
endmodule

bind cbuf_agu cbuf_agu_chk #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_mode  (req_mode),
   .req_size  (req_size),
   .rsp_valid (rsp_valid),
   .rsp_addr  (rsp_addr),
   .rsp_ptr   (rsp_ptr),
   .rsp_err   (rsp_err)
);

// File: tb/tb_cbuf_agu.sv
module tb_cbuf_agu;
   localparam int AW = 32;
   localparam int RB = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_ctx = '0;
   logic [1:0]    cfg_fld = '0;
   logic [AW-1:0] cfg_wdata = '0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_ctx = '0;
   logic [1:0]    req_mode = '0;
   logic [1:0]    req_size = '0;
   logic          req_brev = 1'b0;
   logic [AW-1:0] req_imm = '0;
   logic          rsp_valid;
   logic [AW-1:0] rsp_addr;
   logic [AW-1:0] rsp_ptr;
   logic          rsp_err;

   always #4 clk = ~clk;

   cbuf_agu #(.AW(AW), .NUM_CTX(4), .REV_BITS(RB)) dut (.*);

   int n_cmp = 0;
   int n_bad = 0;
   logic [31:0] m_ptr [4];
   logic [31:0] m_base[4];
   logic [31:0] m_len [4];
   logic [31:0] m_step[4];

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] f_mod(logic [31:0] p, logic [31:0] b, logic [31:0] l, logic [31:0] s);
      longint sum, lo, hi;
      sum = longint'(p) + longint'($signed(s));
      lo  = longint'(b);
      hi  = longint'(b) + longint'(l);
      if (l != 0 && sum >= hi) sum = sum - longint'(l);
      else if (l != 0 && sum < lo) sum = sum + longint'(l);
      return sum[31:0];
   endfunction

   function automatic logic [7:0] f_flip(logic [7:0] v);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = v[7-i];
      return r;
   endfunction

   function automatic logic [31:0] f_rev(logic [31:0] p, logic [31:0] b, logic [31:0] s);
      logic [31:0] off;
      logic [7:0]  t;
      off = p - b;
      t   = f_flip(off[7:0]) + f_flip(s[7:0]);
      off[7:0] = f_flip(t);
      return b + off;
   endfunction

   task automatic wr(input int c, input int f, input logic [31:0] d);
      cfg_we = 1'b1; cfg_ctx = 2'(c); cfg_fld = 2'(f); cfg_wdata = d;
      @(posedge clk); @(negedge clk);
      cfg_we = 1'b0;
      case (f)
         0: m_ptr[c] = d;
         1: m_base[c] = d;
         2: m_len[c] = d;
         default: m_step[c] = d;
      endcase
   endtask

   // issue one request; optionally a pointer write to the same context in the same cycle (R1)
   task automatic req(input int c, input int md, input int sz, input bit br,
                      input logic [31:0] imm, input string tag,
                      input bit co_wr = 1'b0, input logic [31:0] co_val = '0);
      logic [31:0] p, u, ea, ep;
      bit e;
      p = m_ptr[c];
      u = br ? f_rev(p, m_base[c], m_step[c]) : f_mod(p, m_base[c], m_len[c], m_step[c]);
      ea = (md == 0) ? p + imm : (md == 1) ? u : p;
      e = (md == 3) || (sz == 3) || (sz == 1 && ea[0]) || (sz == 2 && ea[1:0] != 0);
      ep = (!e && (md == 1 || md == 2)) ? u : p;
      req_valid = 1'b1; req_ctx = 2'(c); req_mode = 2'(md); req_size = 2'(sz);
      req_brev = br; req_imm = imm;
      if (co_wr) begin cfg_we = 1'b1; cfg_ctx = 2'(c); cfg_fld = 2'd0; cfg_wdata = co_val; end
      @(posedge clk); @(negedge clk);
      req_valid = 1'b0; cfg_we = 1'b0;
      chk(rsp_valid == 1'b1, {tag, " R2 valid"}, 32'(rsp_valid), 32'd1);
      chk(rsp_addr == ea, {tag, " addr"}, rsp_addr, ea);
      chk(rsp_ptr == ep, {tag, " ptr"}, rsp_ptr, ep);
      chk(rsp_err == e, {tag, " R9 err"}, 32'(rsp_err), 32'(e));
      m_ptr[c] = co_wr ? co_val : ep;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      for (int i = 0; i < 4; i++) begin m_ptr[i] = 0; m_base[i] = 0; m_len[i] = 0; m_step[i] = 0; end
      repeat (3) @(negedge clk);
      chk(rsp_valid == 0 && rsp_err == 0, "R2 reset outputs", {30'd0, rsp_valid, rsp_err}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      req(0, 2, 0, 0, 0, "R2 reset pointer zero");

      // R6 upward wrap, R3 post-modify, R10 back to back
      wr(1, 1, 32'h1000); wr(1, 2, 10); wr(1, 3, 3); wr(1, 0, 32'h1008);
      req(1, 2, 0, 0, 0, "R3 R6 post wrap up");
      chk(rsp_ptr == 32'h1001, "R6 literal wrap up", rsp_ptr, 32'h1001);
      req(1, 2, 0, 0, 0, "R10 back-to-back");
      chk(rsp_addr == 32'h1001, "R10 literal", rsp_addr, 32'h1001);

      // R6 downward wrap, R4 pre-modify
      wr(2, 1, 32'h2001); wr(2, 2, 7); wr(2, 3, 32'hFFFF_FFFD); wr(2, 0, 32'h2002);
      req(2, 1, 0, 0, 0, "R4 R6 pre wrap down");
      chk(rsp_addr == 32'h2006, "R6 literal wrap down", rsp_addr, 32'h2006);

      // R7 zero span linear
      wr(3, 1, 32'h10); wr(3, 2, 0); wr(3, 3, 32'hFFFF_FFF8); wr(3, 0, 32'h5);
      req(3, 2, 0, 0, 0, "R7 linear");
      chk(rsp_ptr == 32'hFFFF_FFFD, "R7 literal", rsp_ptr, 32'hFFFF_FFFD);

      // R5 immediate
      req(1, 0, 0, 0, 32'h20, "R5 immediate");
      req(1, 2, 0, 0, 0, "R5 pointer unchanged");

      // R9 misalignment: ctx1 ptr now odd/even mixed
      wr(1, 0, 32'h1003);
      req(1, 2, 1, 0, 0, "R9 two-word misaligned");
      req(1, 2, 2, 0, 0, "R9 four-word misaligned");
      req(1, 2, 3, 0, 0, "R9 reserved size");
      req(1, 3, 0, 0, 0, "R9 reserved mode");
      req(1, 2, 0, 0, 0, "R9 pointer held");
      chk(rsp_addr == 32'h1003, "R9 literal held", rsp_addr, 32'h1003);

      // R8 bit-reversed walk
      wr(0, 1, 32'h300); wr(0, 2, 0); wr(0, 3, 32'h80); wr(0, 0, 32'h300);
      req(0, 2, 0, 1, 0, "R8 brev 0");
      req(0, 2, 0, 1, 0, "R8 brev 1");
      chk(rsp_addr == 32'h380, "R8 literal 1", rsp_addr, 32'h380);
      req(0, 2, 0, 1, 0, "R8 brev 2");
      chk(rsp_addr == 32'h340, "R8 literal 2", rsp_addr, 32'h340);

      // R1 write wins over same-cycle update
      req(2, 2, 0, 0, 0, "R1 co-write", 1'b1, 32'h2004);
      req(2, 2, 0, 0, 0, "R1 written value used");
      chk(rsp_addr == 32'h2004, "R1 literal", rsp_addr, 32'h2004);

      // R2 idle
      @(negedge clk);
      chk(rsp_valid == 0, "R2 idle", 32'(rsp_valid), 0);

      // random phase
      for (int k = 0; k < 2500; k++) begin
         if (k % 200 == 0) begin
            for (int c = 0; c < 4; c++) begin
               logic [31:0] b, l, s;
               b = $urandom_range(0, 32'hFFFF);
               l = ($urandom_range(0, 7) == 0) ? 0 : $urandom_range(1, 512);
               s = $urandom_range(0, 2 * l) - l;
               wr(c, 1, b); wr(c, 2, l); wr(c, 3, s);
               wr(c, 0, (l == 0) ? b : b + $urandom_range(0, l - 1));
            end
         end
         req($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
             ($urandom_range(0, 5) == 0), $urandom_range(0, 255), "R6 R10 random");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule